// File: doc/BRIEF.md
# Indexed UART Register Access Port

This block decodes the host side of a 950-class UART register file. The host sees an 8-bit bus with a 3-bit address and separate read and write strobes. Bus address 7 holds an offset pointer and bus address 5 is a data window. A write to the window lands in the extended register that the pointer selects. A window read returns that register only when the read-enable bit of the additional control register is set. The line control value, the standard divisor latches and the pointer are all stored locally.

A second, locked set of baud parameters lives behind the window. A key value written to a latch offset unlocks it. Each alternative register (divisor low, divisor high, prescaler, sample clock) replaces its standard counterpart on the effective outputs when its own enable bit is set. The baud generator downstream uses those outputs.

While the line control register holds the compatibility code 0xBF, addresses 5 and 7 lead to two compatibility registers instead of the window and the pointer. The serial datapath, the FIFOs and the baud generator are outside this block.

Top module: `uart_idx_regport`

## Requirements
- R1: After reset the line control, divisor low, divisor high, pointer, additional control, enable and compatibility registers are 0x00, the alternative set is locked, the standard prescaler is 0x20 and the standard sample-clock value is 0x00.
- R2: Address 3 reads and writes the line control register. While its bit 7 is set, addresses 0 and 1 read and write the standard divisor low and high bytes. While bit 7 is clear, writes to them are ignored and reads return 0x00.
- R3: When the line control value is not 0xBF, address 7 reads and writes the 8-bit offset pointer.
- R4: A write to address 5 (line control not 0xBF) stores the data in the extended register at the pointer. Offset 0x00 is the additional control register, 0x01 the standard prescaler and 0x02 the standard sample-clock value.
- R5: A read of address 5 (line control not 0xBF) returns 0x00 while bit 6 of the additional control register is clear, and the extended register at the pointer while it is set.
- R6: While the line control value is 0xBF, addresses 5 and 7 read and write two separate compatibility registers. The pointer and the extended registers are left unchanged.
- R7: Writing 0xEB to offset 0x30 unlocks the alternative set. Writing any other value there locks it. Offset 0x30 reads 0x01 while unlocked and 0x00 while locked.
- R8: While locked, writes to offsets 0x31 to 0x35 are ignored and reads of them return 0x00.
- R9: Offset 0x31 keeps four enable bits: bit 0 divisor low, bit 1 divisor high, bit 2 prescaler, bit 3 sample clock. Bits 7 to 4 read as zero.
- R10: Offsets 0x32, 0x33, 0x34 and 0x35 hold the alternative divisor low, divisor high, prescaler and sample-clock values. Each effective output carries the alternative value when its enable bit is set and the standard value otherwise, whether the set is locked or not.
- R11: Writes to offsets 0x03 to 0x2F and 0x36 to 0xFF are ignored, and reads of them return 0x00.
- R12: rdata loads the addressed value on the clock edge at which rd is high and holds it while rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Bus register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| rdata | output | 8 | Registered read data |
| eff_dll | output | 8 | Effective divisor low byte |
| eff_dlm | output | 8 | Effective divisor high byte |
| eff_cpr | output | 8 | Effective prescaler value |
| eff_tcr | output | 8 | Effective sample-clock value |

## Verification
The properties watch, on every cycle, that rdata holds between reads and that line control writes take effect. They check that the key write sets or clears the lock as the data dictates, and that a window write to the locked range leaves the enables and effective outputs untouched. They also check that compatibility-mode writes leave the pointer and lock alone, and that a standard divisor write reaches its output while the override bit is clear. Only the bench scenarios can show the full offset map: the read-back of every reserved offset, the enable masks across all sixteen combinations, and the persistence of enables after re-locking.

// File: rtl/uart_idx_pkg.sv
package uart_idx_pkg;
  localparam int unsigned BW = 8;
  localparam int unsigned NALT = 4;
  localparam logic [BW-1:0] OFS_ACR   = 8'h00;
  localparam logic [BW-1:0] OFS_CPR   = 8'h01;
  localparam logic [BW-1:0] OFS_TCR   = 8'h02;
  localparam logic [BW-1:0] OFS_LATCH = 8'h30;
  localparam logic [BW-1:0] OFS_AEN   = 8'h31;
  localparam logic [BW-1:0] OFS_ALT0  = 8'h32;
  localparam int unsigned ACR_RDEN_BIT = 6;
  typedef logic [BW-1:0] byte_t;
endpackage

// File: rtl/uart_idx_bank.sv
module uart_idx_bank
  import uart_idx_pkg::*;
#(
  parameter byte_t UNLOCK_KEY = 8'hEB,
  parameter byte_t CPR_RST    = 8'h20,
  parameter byte_t TCR_RST    = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  byte_t            ofs,
  input  byte_t            wdata,
  output byte_t            acr,
  output byte_t            std_cpr,
  output byte_t            std_tcr,
  output logic             unlocked,
  output logic [NALT-1:0]  alt_en,
  output byte_t            alt_val [NALT],
  output byte_t            rd_val
);
  byte_t acr_q, cpr_q, tcr_q;
  logic unl_q;
  logic [NALT-1:0] en_q;

  logic acr_we, cpr_we, tcr_we, latch_we, aen_we;
  byte_t unused_hi;

  always_comb begin
    acr_we   = we && (ofs == OFS_ACR);
    cpr_we   = we && (ofs == OFS_CPR);
    tcr_we   = we && (ofs == OFS_TCR);
    latch_we = we && (ofs == OFS_LATCH);
    aen_we   = we && unl_q && (ofs == OFS_AEN);
    unused_hi = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acr_q <= '0;
      cpr_q <= CPR_RST;
      tcr_q <= TCR_RST;
      unl_q <= 1'b0;
      en_q  <= '0;
    end else begin
      if (acr_we)   acr_q <= wdata;
      if (cpr_we)   cpr_q <= wdata;
      if (tcr_we)   tcr_q <= wdata;
      if (latch_we) unl_q <= (wdata == UNLOCK_KEY);
      if (aen_we)   en_q  <= unused_hi[NALT-1:0];
    end
  end

  for (genvar gi = 0; gi < NALT; gi++) begin : g_alt
    byte_t q;
    logic  alt_we;
    assign alt_we = we && unl_q && (ofs == OFS_ALT0 + byte_t'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (alt_we) q <= wdata;
    end
    assign alt_val[gi] = q;
  end

  always_comb begin
    rd_val = '0;
    if (ofs == OFS_ACR)        rd_val = acr_q;
    else if (ofs == OFS_CPR)   rd_val = cpr_q;
    else if (ofs == OFS_TCR)   rd_val = tcr_q;
    else if (ofs == OFS_LATCH) rd_val = {{(BW-1){1'b0}}, unl_q};
    else if (ofs == OFS_AEN)   rd_val = unl_q ? {{(BW-NALT){1'b0}}, en_q} : '0;
    else begin
      for (int k = 0; k < NALT; k++) begin
        if (unl_q && (ofs == OFS_ALT0 + byte_t'(k))) rd_val = alt_val[k];
      end
    end
  end

  assign acr      = acr_q;
  assign std_cpr  = cpr_q;
  assign std_tcr  = tcr_q;
  assign unlocked = unl_q;
  assign alt_en   = en_q;
endmodule

// File: rtl/uart_idx_host.sv
module uart_idx_host
  import uart_idx_pkg::*;
#(
  parameter byte_t COMPAT_LCR = 8'hBF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  byte_t      wdata,
  input  logic       wr,
  input  logic       rd,
  input  byte_t      bank_rd,
  input  logic       rd_en,
  output logic       bank_we,
  output byte_t      ptr,
  output byte_t      lcr,
  output byte_t      std_dll,
  output byte_t      std_dlm,
  output byte_t      rdata
);
  localparam logic [2:0] A_DLL = 3'd0;
  localparam logic [2:0] A_DLM = 3'd1;
  localparam logic [2:0] A_LCR = 3'd3;
  localparam logic [2:0] A_WIN = 3'd5;
  localparam logic [2:0] A_PTR = 3'd7;

  byte_t lcr_q, dll_q, dlm_q, ptr_q, cmp5_q, cmp7_q, rdata_q;
  logic compat, dlab;
  logic lcr_we, dll_we, dlm_we, ptr_we, c5_we, c7_we;
  byte_t rd_mux;

  always_comb begin
    compat  = (lcr_q == COMPAT_LCR);
    dlab    = lcr_q[BW-1];
    lcr_we  = wr && (addr == A_LCR);
    dll_we  = wr && dlab && (addr == A_DLL);
    dlm_we  = wr && dlab && (addr == A_DLM);
    bank_we = wr && !compat && (addr == A_WIN);
    c5_we   = wr && compat && (addr == A_WIN);
    ptr_we  = wr && !compat && (addr == A_PTR);
    c7_we   = wr && compat && (addr == A_PTR);
    case (addr)
      A_DLL:   rd_mux = dlab ? dll_q : '0;
      A_DLM:   rd_mux = dlab ? dlm_q : '0;
      A_LCR:   rd_mux = lcr_q;
      A_WIN:   rd_mux = compat ? cmp5_q : (rd_en ? bank_rd : '0);
      A_PTR:   rd_mux = compat ? cmp7_q : ptr_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q   <= '0;
      dll_q   <= '0;
      dlm_q   <= '0;
      ptr_q   <= '0;
      cmp5_q  <= '0;
      cmp7_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (lcr_we) lcr_q   <= wdata;
      if (dll_we) dll_q   <= wdata;
      if (dlm_we) dlm_q   <= wdata;
      if (ptr_we) ptr_q   <= wdata;
      if (c5_we)  cmp5_q  <= wdata;
      if (c7_we)  cmp7_q  <= wdata;
      if (rd)     rdata_q <= rd_mux;
    end
  end

  assign ptr     = ptr_q;
  assign lcr     = lcr_q;
  assign std_dll = dll_q;
  assign std_dlm = dlm_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/uart_baud_sel.sv
module uart_baud_sel
  import uart_idx_pkg::*;
(
  input  logic [NALT-1:0] en,
  input  byte_t           std_val [NALT],
  input  byte_t           alt_val [NALT],
  output byte_t           eff_val [NALT]
);
  for (genvar gi = 0; gi < NALT; gi++) begin : g_sel
    assign eff_val[gi] = en[gi] ? alt_val[gi] : std_val[gi];
  end
endmodule

// File: rtl/uart_idx_regport.sv
module uart_idx_regport
  import uart_idx_pkg::*;
#(
  parameter byte_t UNLOCK_KEY = 8'hEB,
  parameter byte_t COMPAT_LCR = 8'hBF,
  parameter byte_t CPR_RST    = 8'h20,
  parameter byte_t TCR_RST    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  output logic [7:0] eff_dll,
  output logic [7:0] eff_dlm,
  output logic [7:0] eff_cpr,
  output logic [7:0] eff_tcr
);
  logic [1:0] rst_sync;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  logic bank_we, unlocked;
  byte_t ptr, lcr, std_dll, std_dlm, std_cpr, std_tcr, acr, bank_rd;
  logic [NALT-1:0] alt_en;
  byte_t alt_val [NALT];
  byte_t std_val [NALT];
  byte_t eff_val [NALT];

  uart_idx_host #(.COMPAT_LCR(COMPAT_LCR)) u_host (
    .clk(clk), .rst_n(rst_sync_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .bank_rd(bank_rd), .rd_en(acr[ACR_RDEN_BIT]), .bank_we(bank_we), .ptr(ptr),
    .lcr(lcr), .std_dll(std_dll), .std_dlm(std_dlm), .rdata(rdata)
  );

  uart_idx_bank #(.UNLOCK_KEY(UNLOCK_KEY), .CPR_RST(CPR_RST), .TCR_RST(TCR_RST)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .we(bank_we), .ofs(ptr), .wdata(wdata),
    .acr(acr), .std_cpr(std_cpr), .std_tcr(std_tcr), .unlocked(unlocked),
    .alt_en(alt_en), .alt_val(alt_val), .rd_val(bank_rd)
  );

  assign std_val[0] = std_dll;
  assign std_val[1] = std_dlm;
  assign std_val[2] = std_cpr;
  assign std_val[3] = std_tcr;

  uart_baud_sel u_sel (.en(alt_en), .std_val(std_val), .alt_val(alt_val), .eff_val(eff_val));

  assign eff_dll = eff_val[0];
  assign eff_dlm = eff_val[1];
  assign eff_cpr = eff_val[2];
  assign eff_tcr = eff_val[3];
endmodule

// File: rtl/uart_idx_regport_chk.sv
module uart_idx_regport_chk #(
  parameter logic [7:0] UNLOCK_KEY = 8'hEB,
  parameter logic [7:0] COMPAT_LCR = 8'hBF
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic       wr,
  input logic       rd,
  input logic [7:0] rdata,
  input logic [7:0] lcr,
  input logic [7:0] ptr,
  input logic       unlocked,
  input logic [3:0] alt_en,
  input logic [7:0] eff_dll,
  input logic [7:0] eff_dlm,
  input logic [7:0] eff_cpr,
  input logic [7:0] eff_tcr
);
  logic win_wr;
  assign win_wr = wr && (addr == 3'd5) && (lcr != COMPAT_LCR);

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  assert_lcr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd3) |=> (lcr == $past(wdata)));

  assert_latch_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && ptr == 8'h30) |=> (unlocked == ($past(wdata) == UNLOCK_KEY)));

  assert_locked_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && !unlocked && ptr >= 8'h31 && ptr <= 8'h35) |=>
      ($stable(alt_en) && $stable(unlocked) && $stable(eff_dll) && $stable(eff_dlm)
       && $stable(eff_cpr) && $stable(eff_tcr)));

  assert_compat_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && lcr == COMPAT_LCR && (addr == 3'd5 || addr == 3'd7)) |=>
      ($stable(ptr) && $stable(unlocked) && $stable(alt_en)));

  assert_std_dll_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd0 && lcr[7] && !alt_en[0]) |=> (eff_dll == $past(wdata)));
endmodule

bind uart_idx_regport uart_idx_regport_chk #(.UNLOCK_KEY(UNLOCK_KEY), .COMPAT_LCR(COMPAT_LCR)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
  .rdata(rdata), .lcr(lcr), .ptr(ptr), .unlocked(unlocked), .alt_en(alt_en),
  .eff_dll(eff_dll), .eff_dlm(eff_dlm), .eff_cpr(eff_cpr), .eff_tcr(eff_tcr)
);

// File: tb/uart_idx_regport_bench.sv
module uart_idx_regport_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata, eff_dll, eff_dlm, eff_cpr, eff_tcr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_idx_regport u_uart_idx_regport (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .eff_dll(eff_dll), .eff_dlm(eff_dlm), .eff_cpr(eff_cpr), .eff_tcr(eff_tcr)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idx_wr(input logic [7:0] o, input logic [7:0] d);
    bus_wr(3'd7, o); bus_wr(3'd5, d);
  endtask

  task automatic idx_rd(input logic [7:0] o, output logic [7:0] d);
    bus_wr(3'd7, o); bus_rd(3'd5, d);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] altv [4];
    logic [7:0] stdv [4];
    logic [7:0] effv [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_rd(3'd3, v); chk("R1 lcr", v, 8'h00);
    bus_rd(3'd7, v); chk("R1 ptr", v, 8'h00);
    chk("R1 eff_dll", eff_dll, 8'h00); chk("R1 eff_dlm", eff_dlm, 8'h00);
    chk("R1 eff_cpr", eff_cpr, 8'h20); chk("R1 eff_tcr", eff_tcr, 8'h00);
    bus_wr(3'd7, 8'h00); bus_wr(3'd5, 8'h40);
    idx_rd(8'h30, v); chk("R1 locked", v, 8'h00);
    idx_rd(8'h00, v); chk("R1 acr after write", v, 8'h40);
    bus_wr(3'd5, 8'h00);

    // R2 divisor sweep with DLAB set
    bus_wr(3'd3, 8'h80);
    for (int i = 0; i < 256; i += 17) begin
      bus_wr(3'd0, 8'(i)); bus_wr(3'd1, 8'(255 - i));
      chk("R2 eff_dll", eff_dll, 8'(i)); chk("R2 eff_dlm", eff_dlm, 8'(255 - i));
      bus_rd(3'd0, v); chk("R2 dll rd", v, 8'(i));
    end
    bus_wr(3'd0, 8'h5A); bus_wr(3'd1, 8'hA5);
    bus_wr(3'd3, 8'h03);
    bus_wr(3'd0, 8'h99);
    chk("R2 dll ignored", eff_dll, 8'h5A);
    bus_rd(3'd0, v); chk("R2 dll rd zero", v, 8'h00);
    bus_rd(3'd3, v); chk("R2 lcr rd", v, 8'h03);

    // R3 pointer sweep
    for (int i = 0; i < 256; i += 5) begin
      bus_wr(3'd7, 8'(i)); bus_rd(3'd7, v); chk("R3 ptr", v, 8'(i));
    end

    // R4 / R5 window
    idx_wr(8'h01, 8'h0A); idx_wr(8'h02, 8'h0C);
    chk("R4 eff_cpr", eff_cpr, 8'h0A); chk("R4 eff_tcr", eff_tcr, 8'h0C);
    idx_rd(8'h01, v); chk("R5 rd gated", v, 8'h00);
    idx_wr(8'h00, 8'h40);
    idx_rd(8'h01, v); chk("R5 cpr rd", v, 8'h0A);
    idx_rd(8'h02, v); chk("R5 tcr rd", v, 8'h0C);

    // R11 reserved offsets
    for (int o = 3; o < 256; o++) begin
      if (o >= 8'h30 && o <= 8'h35) continue;
      idx_wr(8'(o), 8'hA5); bus_rd(3'd5, v); chk("R11 reserved", v, 8'h00);
    end
    idx_rd(8'h00, v); chk("R11 acr kept", v, 8'h40);
    chk("R11 cpr kept", eff_cpr, 8'h0A);

    // R8 locked range
    for (int o = 8'h31; o <= 8'h35; o++) begin
      idx_wr(8'(o), 8'h0F); bus_rd(3'd5, v); chk("R8 locked rd", v, 8'h00);
    end
    chk("R8 eff_dll", eff_dll, 8'h5A); chk("R8 eff_tcr", eff_tcr, 8'h0C);

    // R7 unlock
    idx_wr(8'h30, 8'hEB); bus_rd(3'd5, v); chk("R7 unlocked", v, 8'h01);
    for (int k = 0; k < 4; k++) begin
      altv[k] = 8'(8'h11 * (k + 1));
      idx_wr(8'(8'h32 + k), altv[k]); bus_rd(3'd5, v); chk("R10 alt rd", v, altv[k]);
    end
    stdv[0] = 8'h5A; stdv[1] = 8'hA5; stdv[2] = 8'h0A; stdv[3] = 8'h0C;

    // R9 / R10 enable masks
    for (int m = 0; m < 16; m++) begin
      idx_wr(8'h31, 8'(m) | 8'hF0); bus_rd(3'd5, v); chk("R9 enable rd", v, 8'(m));
      effv[0] = eff_dll; effv[1] = eff_dlm; effv[2] = eff_cpr; effv[3] = eff_tcr;
      for (int k = 0; k < 4; k++)
        chk("R10 eff", effv[k], m[k] ? altv[k] : stdv[k]);
    end

    // R7 relock, enables persist (R10)
    idx_wr(8'h31, 8'h05);
    idx_wr(8'h30, 8'hEA); bus_rd(3'd5, v); chk("R7 relocked", v, 8'h00);
    idx_rd(8'h31, v); chk("R8 enable hidden", v, 8'h00);
    chk("R10 persist dll", eff_dll, altv[0]); chk("R10 persist dlm", eff_dlm, stdv[1]);
    chk("R10 persist cpr", eff_cpr, altv[2]);

    // R6 compatibility mode
    bus_wr(3'd7, 8'h02);
    bus_wr(3'd3, 8'hBF);
    bus_wr(3'd7, 8'h99); bus_wr(3'd5, 8'h66);
    bus_rd(3'd7, v); chk("R6 cmp7", v, 8'h99);
    bus_rd(3'd5, v); chk("R6 cmp5", v, 8'h66);
    bus_wr(3'd3, 8'h03);
    bus_rd(3'd7, v); chk("R6 ptr kept", v, 8'h02);
    bus_rd(3'd5, v); chk("R6 tcr kept", v, 8'h0C);

    // R12 hold
    bus_rd(3'd3, v);
    @(negedge clk); addr = 3'd7;
    repeat (3) @(negedge clk);
    chk("R12 hold", rdata, 8'h03);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule